// File: doc/BRIEF.md
# Ring-Queue DMA Channel Control Block

This block holds the control and status registers for a group of memory-copy DMA channels. Each channel is driven by a pair of rings in memory: a submission ring of work elements and a completion ring. Software programs the ring bases and sizes, then advances the submission tail pointer to post work. A per-channel state machine compares that tail with its own head pointer. It launches one element at a time to a separate copy engine through a start/done handshake, and it raises the channel interrupt.

Every channel has an identical register window, and the windows repeat at a 256-byte stride. Software can enable or pause a channel. It can reset a channel through a self-clearing request bit, and it reads the state machine's encoded state to confirm that the channel has drained or returned to idle. Interrupt sources are latched in a status register that is cleared by writing ones. A mask register blocks individual sources.

Top module: `dmaq_ctrl`

## Requirements
- R1: After reset, every channel reads state 0 (idle), tail 0, completion head 0, control 0, interrupt status 0 and interrupt mask 0x1FFF. Every irq output is low.
- R2: Within a channel window (channel n at byte address n*0x100), the following registers read back the last value written: submission base low 0x00 and high 0x04, submission depth 0x08 (low PTR_W bits), submission tail 0x0C, completion base low 0x10 and high 0x14, completion depth 0x18, completion head 0x1C, and control 0x20 (enable bit 0, pause bit 4). A write to one channel leaves the other channels unchanged. The submission base is presented on eng_sq_base as {high, low}.
- R3: When a channel is enabled, not paused and idle, and its tail differs from its internal head, the channel gives a one-cycle eng_start pulse with eng_index equal to the head. A disabled channel starts nothing.
- R4: A successful eng_done advances the head by one. The head wraps to 0 after reaching the depth value, so the depth register holds the number of entries minus one. The channel keeps launching elements in ring order until the head equals the tail, and then it returns to idle.
- R5: Setting pause (bit 4 of 0x20) lets the element in flight finish. The state then reads 3 (pause), and no new element starts until pause is cleared.
- R6: Writing 1 to bit 0 of 0x24 resets the channel. The request bit reads back 0 afterwards. The state reads 7 (flush) for one cycle and then 0. The internal head, the tail and the completion head all return to 0.
- R7: The state register at 0x30 (bits [3:0]) encodes idle=0, run=1, complete=2, pause=3, halt=4. Status at 0x40 has 13 bits. Bit 0 is set when an element completes with its interrupt-enable flag set. Bit 1 is set, and the state goes to halt, when the engine reports an error. Halt persists until a reset, and writing 1 to a status bit clears it.
- R8: irq of a channel is high exactly when some status bit is set whose mask bit (0x44, 1 = blocked) is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; bits [7:0] offset, upper bits channel |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the request |
| bus_rvalid | output | 1 | Read data valid |
| eng_start | output | NCH | One-cycle launch pulse per channel |
| eng_index | output | NCH*PTR_W | Ring slot of the launched element per channel |
| eng_sq_base | output | NCH*64 | Submission ring base per channel |
| eng_cq_base | output | NCH*64 | Completion ring base per channel |
| eng_done | input | NCH | Element finished |
| eng_err | input | NCH | Element failed, qualified by eng_done |
| eng_ien | input | NCH | Element requested an interrupt, qualified by eng_done |
| irq | output | NCH | Channel interrupt |

## Verification
On every cycle the assertions check the handshake and state-machine rules. A launch only happens in the run state and never right after pause was sampled. The head moves only out of the complete state or on a reset. Halt holds until a reset, flush lasts one cycle, the reset request clears itself, and the completion status bit rises only after a completion event. Other properties need a whole sequence and only the bench scenarios show them: the slot order across ring wraps for many depths and step sizes, the exact number of elements processed, pause taking effect after the element in flight, and the read-back of registers through the bus.

// File: rtl/dmaq_pkg.sv
package dmaq_pkg;

    localparam int DATA_W = 32;
    localparam int STS_W  = 13;
    localparam int STS_DONE  = 0;
    localparam int STS_FAULT = 1;

    localparam logic [7:0] OFF_SUB_LO   = 8'h00;
    localparam logic [7:0] OFF_SUB_HI   = 8'h04;
    localparam logic [7:0] OFF_SUB_SIZE = 8'h08;
    localparam logic [7:0] OFF_SUB_TAIL = 8'h0C;
    localparam logic [7:0] OFF_CPL_LO   = 8'h10;
    localparam logic [7:0] OFF_CPL_HI   = 8'h14;
    localparam logic [7:0] OFF_CPL_SIZE = 8'h18;
    localparam logic [7:0] OFF_CPL_HEAD = 8'h1C;
    localparam logic [7:0] OFF_CTL      = 8'h20;
    localparam logic [7:0] OFF_RSTREQ   = 8'h24;
    localparam logic [7:0] OFF_STATE    = 8'h30;
    localparam logic [7:0] OFF_ISTAT    = 8'h40;
    localparam logic [7:0] OFF_IMASK    = 8'h44;

    localparam int CTL_EN_BIT    = 0;
    localparam int CTL_PAUSE_BIT = 4;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_RUN   = 3'd1,
        ST_DONE  = 3'd2,
        ST_HOLD  = 3'd3,
        ST_FAULT = 3'd4,
        ST_ABORT = 3'd5,
        ST_WAIT  = 3'd6,
        ST_FLUSH = 3'd7
    } chan_state_e;

    typedef struct packed {
        logic en;
        logic pause;
    } chan_ctl_t;

    typedef struct packed {
        logic cpl;
        logic fault;
    } chan_evt_t;

    function automatic logic [15:0] ring_step(input logic [15:0] ptr, input logic [15:0] last);
        return (ptr == last) ? 16'd0 : ptr + 16'd1;
    endfunction

endpackage

// File: rtl/dmaq_chan_fsm.sv
module dmaq_chan_fsm
    import dmaq_pkg::*;
#(
    parameter int PTR_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  chan_ctl_t        ctl,
    input  logic             rst_req,
    input  logic [PTR_W-1:0] tail,
    input  logic [PTR_W-1:0] last_slot,
    input  logic             done,
    input  logic             err,
    input  logic             ien,
    output chan_state_e      state,
    output logic [PTR_W-1:0] head,
    output logic             start,
    output chan_evt_t        evt
);

    chan_state_e      state_q;
    logic [PTR_W-1:0] head_q;
    logic             start_q;
    chan_evt_t        evt_q;
    logic             work_pending;
    logic [PTR_W-1:0] head_next;

    assign work_pending = ctl.en && (tail != head_q);
    assign head_next    = PTR_W'(ring_step(16'(head_q), 16'(last_slot)));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            head_q  <= '0;
            start_q <= 1'b0;
            evt_q   <= '0;
        end else begin
            start_q <= 1'b0;
            evt_q   <= '0;
            if (rst_req) begin
                state_q <= ST_FLUSH;
                head_q  <= '0;
            end else begin
                unique case (state_q)
                    ST_IDLE: begin
                        if (ctl.en && ctl.pause) begin
                            state_q <= ST_HOLD;
                        end else if (work_pending) begin
                            state_q <= ST_RUN;
                            start_q <= 1'b1;
                        end
                    end
                    ST_RUN: begin
                        if (done) begin
                            if (err) begin
                                state_q     <= ST_FAULT;
                                evt_q.fault <= 1'b1;
                            end else begin
                                state_q   <= ST_DONE;
                                evt_q.cpl <= ien;
                            end
                        end
                    end
                    ST_DONE: begin
                        head_q  <= head_next;
                        state_q <= ctl.pause ? ST_HOLD : ST_IDLE;
                    end
                    ST_HOLD: begin
                        if (!ctl.pause || !ctl.en) state_q <= ST_IDLE;
                    end
                    ST_FAULT: state_q <= ST_FAULT;
                    default:  state_q <= ST_IDLE;
                endcase
            end
        end
    end

    assign state = state_q;
    assign head  = head_q;
    assign start = start_q;
    assign evt   = evt_q;

    AST_START_IN_RUN: assert property (@(posedge clk) disable iff (rst)
        start_q |-> state_q == ST_RUN); // R3

    AST_NO_LAUNCH_PAUSED: assert property (@(posedge clk) disable iff (rst)
        $past(ctl.pause) |-> !start_q); // R5

    AST_HEAD_MOVES: assert property (@(posedge clk) disable iff (rst)
        !$stable(head_q) |-> ($past(state_q) == ST_DONE) || $past(rst_req)); // R4

    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FAULT) && !rst_req |=> state_q == ST_FAULT); // R7

    AST_FLUSH_ONE: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FLUSH) && !rst_req |=> state_q == ST_IDLE); // R6

endmodule

// File: rtl/dmaq_chan_regs.sv
module dmaq_chan_regs
    import dmaq_pkg::*;
#(
    parameter int PTR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [7:0]        off,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_data,
    input  chan_state_e       state,
    input  chan_evt_t         evt,
    output logic [63:0]       sq_base,
    output logic [63:0]       cq_base,
    output logic [PTR_W-1:0]  sq_last,
    output logic [PTR_W-1:0]  tail,
    output chan_ctl_t         ctl,
    output logic              rst_req,
    output logic              irq
);

    logic [63:0]      sq_base_q, cq_base_q;
    logic [PTR_W-1:0] sq_last_q, cq_last_q, tail_q, cq_head_q;
    chan_ctl_t        ctl_q;
    logic             rst_req_q;
    logic [STS_W-1:0] sts_q, msk_q, sts_set, sts_clr;

    always_comb begin
        sts_set            = '0;
        sts_set[STS_DONE]  = evt.cpl;
        sts_set[STS_FAULT] = evt.fault;
        sts_clr            = (wr_en && off == OFF_ISTAT) ? wdata[STS_W-1:0] : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sq_base_q <= '0;
            cq_base_q <= '0;
            sq_last_q <= '0;
            cq_last_q <= '0;
            tail_q    <= '0;
            cq_head_q <= '0;
            ctl_q     <= '0;
            rst_req_q <= 1'b0;
            sts_q     <= '0;
            msk_q     <= '1;
        end else begin
            rst_req_q <= 1'b0;
            if (wr_en) begin
                unique case (off)
                    OFF_SUB_LO:   sq_base_q[31:0]  <= wdata;
                    OFF_SUB_HI:   sq_base_q[63:32] <= wdata;
                    OFF_SUB_SIZE: sq_last_q        <= wdata[PTR_W-1:0];
                    OFF_SUB_TAIL: tail_q           <= wdata[PTR_W-1:0];
                    OFF_CPL_LO:   cq_base_q[31:0]  <= wdata;
                    OFF_CPL_HI:   cq_base_q[63:32] <= wdata;
                    OFF_CPL_SIZE: cq_last_q        <= wdata[PTR_W-1:0];
                    OFF_CPL_HEAD: cq_head_q        <= wdata[PTR_W-1:0];
                    OFF_CTL: begin
                        ctl_q.en    <= wdata[CTL_EN_BIT];
                        ctl_q.pause <= wdata[CTL_PAUSE_BIT];
                    end
                    OFF_RSTREQ:   rst_req_q <= wdata[0];
                    OFF_IMASK:    msk_q     <= wdata[STS_W-1:0];
                    default: ;
                endcase
            end
            if (rst_req_q) begin
                tail_q    <= '0;
                cq_head_q <= '0;
            end
            sts_q <= (sts_q & ~sts_clr) | sts_set;
        end
    end

    always_comb begin
        unique case (off)
            OFF_SUB_LO:   rd_data = sq_base_q[31:0];
            OFF_SUB_HI:   rd_data = sq_base_q[63:32];
            OFF_SUB_SIZE: rd_data = 32'(sq_last_q);
            OFF_SUB_TAIL: rd_data = 32'(tail_q);
            OFF_CPL_LO:   rd_data = cq_base_q[31:0];
            OFF_CPL_HI:   rd_data = cq_base_q[63:32];
            OFF_CPL_SIZE: rd_data = 32'(cq_last_q);
            OFF_CPL_HEAD: rd_data = 32'(cq_head_q);
            OFF_CTL: begin
                rd_data                = '0;
                rd_data[CTL_EN_BIT]    = ctl_q.en;
                rd_data[CTL_PAUSE_BIT] = ctl_q.pause;
            end
            OFF_RSTREQ:   rd_data = 32'(rst_req_q);
            OFF_STATE:    rd_data = 32'(state);
            OFF_ISTAT:    rd_data = 32'(sts_q);
            OFF_IMASK:    rd_data = 32'(msk_q);
            default:      rd_data = '0;
        endcase
    end

    assign sq_base = sq_base_q;
    assign cq_base = cq_base_q;
    assign sq_last = sq_last_q;
    assign tail    = tail_q;
    assign ctl     = ctl_q;
    assign rst_req = rst_req_q;
    assign irq     = |(sts_q & ~msk_q);

    AST_RSTREQ_SELF_CLR: assert property (@(posedge clk) disable iff (rst)
        rst_req_q && !(wr_en && off == OFF_RSTREQ) |=> !rst_req_q); // R6

    AST_DONE_FLAG_SRC: assert property (@(posedge clk) disable iff (rst)
        $rose(sts_q[STS_DONE]) |-> $past(evt.cpl)); // R7

endmodule

// File: rtl/dmaq_ctrl.sv
module dmaq_ctrl
    import dmaq_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int PTR_W  = 10,
    parameter int ADDR_W = 12
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_req,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    output logic                  bus_rvalid,
    output logic [NCH-1:0]        eng_start,
    output logic [NCH*PTR_W-1:0]  eng_index,
    output logic [NCH*64-1:0]     eng_sq_base,
    output logic [NCH*64-1:0]     eng_cq_base,
    input  logic [NCH-1:0]        eng_done,
    input  logic [NCH-1:0]        eng_err,
    input  logic [NCH-1:0]        eng_ien,
    output logic [NCH-1:0]        irq
);

    localparam int CHF_W = ADDR_W - 8;

    logic [CHF_W-1:0] chan_field;
    logic [7:0]       off;
    logic [NCH-1:0]   sel;
    logic [31:0]      ch_rd [NCH];
    logic [31:0]      rd_mux;
    logic [31:0]      rdata_q;
    logic             rvalid_q;

    assign chan_field = bus_addr[ADDR_W-1:8];
    assign off        = bus_addr[7:0];

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        chan_state_e      state;
        chan_evt_t        evt;
        chan_ctl_t        ctl;
        logic [PTR_W-1:0] sq_last, tail, head;
        logic             rst_req;

        assign sel[c] = (chan_field == CHF_W'(c));

        dmaq_chan_regs #(.PTR_W(PTR_W)) u_regs (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (bus_req && bus_wr && sel[c]),
            .off     (off),
            .wdata   (bus_wdata),
            .rd_data (ch_rd[c]),
            .state   (state),
            .evt     (evt),
            .sq_base (eng_sq_base[c*64 +: 64]),
            .cq_base (eng_cq_base[c*64 +: 64]),
            .sq_last (sq_last),
            .tail    (tail),
            .ctl     (ctl),
            .rst_req (rst_req),
            .irq     (irq[c])
        );

        dmaq_chan_fsm #(.PTR_W(PTR_W)) u_fsm (
            .clk       (clk),
            .rst       (rst),
            .ctl       (ctl),
            .rst_req   (rst_req),
            .tail      (tail),
            .last_slot (sq_last),
            .done      (eng_done[c]),
            .err       (eng_err[c]),
            .ien       (eng_ien[c]),
            .state     (state),
            .head      (head),
            .start     (eng_start[c]),
            .evt       (evt)
        );

        assign eng_index[c*PTR_W +: PTR_W] = head;
    end

    always_comb begin
        rd_mux = '0;
        for (int c = 0; c < NCH; c++) begin
            if (sel[c]) rd_mux = ch_rd[c];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= bus_req && !bus_wr;
            if (bus_req && !bus_wr) rdata_q <= rd_mux;
        end
    end

    assign bus_rdata  = rdata_q;
    assign bus_rvalid = rvalid_q;

endmodule

// File: tb/dmaq_ctrl_bench.sv
module dmaq_ctrl_bench;

    localparam int NCH    = 2;
    localparam int PTR_W  = 4;
    localparam int ADDR_W = 12;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 bus_req = 1'b0;
    logic                 bus_wr = 1'b0;
    logic [ADDR_W-1:0]    bus_addr = '0;
    logic [31:0]          bus_wdata = '0;
    logic [31:0]          bus_rdata;
    logic                 bus_rvalid;
    logic [NCH-1:0]       eng_start;
    logic [NCH*PTR_W-1:0] eng_index;
    logic [NCH*64-1:0]    eng_sq_base;
    logic [NCH*64-1:0]    eng_cq_base;
    logic [NCH-1:0]       eng_done = '0;
    logic [NCH-1:0]       eng_err = '0;
    logic [NCH-1:0]       eng_ien = '0;
    logic [NCH-1:0]       irq;

    int checks = 0;
    int fails  = 0;
    int lat    = 2;
    int starts  [NCH];
    int exp_idx [NCH];
    int last_m  [NCH];
    int cnt     [NCH];
    bit pend    [NCH];

    always #2.5 clk = ~clk;

    dmaq_ctrl #(.NCH(NCH), .PTR_W(PTR_W), .ADDR_W(ADDR_W)) u_dmaq_ctrl (
        .clk(clk), .rst(rst),
        .bus_req(bus_req), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .eng_start(eng_start), .eng_index(eng_index),
        .eng_sq_base(eng_sq_base), .eng_cq_base(eng_cq_base),
        .eng_done(eng_done), .eng_err(eng_err), .eng_ien(eng_ien),
        .irq(irq)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int ch, input logic [7:0] o, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_wr = 1'b1;
        bus_addr = ADDR_W'(ch * 256 + int'(o)); bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input int ch, input logic [7:0] o, output logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_wr = 1'b0;
        bus_addr = ADDR_W'(ch * 256 + int'(o));
        @(negedge clk);
        bus_req = 1'b0;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // engine model: checks launch order, answers with eng_done after lat+1 cycles
    always @(negedge clk) begin
        for (int c = 0; c < NCH; c++) begin
            if (eng_done[c]) eng_done[c] = 1'b0;
            if (pend[c]) begin
                if (cnt[c] == 0) begin
                    eng_done[c] = 1'b1;
                    pend[c] = 1'b0;
                end else cnt[c]--;
            end
            if (!rst && eng_start[c]) begin
                check("R3/R4 launch slot", 64'(eng_index[c*PTR_W +: PTR_W]), 64'(exp_idx[c]));
                exp_idx[c] = (exp_idx[c] == last_m[c]) ? 0 : exp_idx[c] + 1;
                starts[c]++;
                pend[c] = 1'b1;
                cnt[c] = lat;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int t, total, round, n;
        for (int c = 0; c < NCH; c++) begin
            starts[c] = 0; exp_idx[c] = 0; last_m[c] = 0; cnt[c] = 0; pend[c] = 0;
        end
        idle(4);
        rst = 1'b0;

        // R1 reset values
        for (int c = 0; c < NCH; c++) begin
            rd(c, 8'h30, d); check("R1 state", 64'(d), 64'd0);
            rd(c, 8'h0C, d); check("R1 tail", 64'(d), 64'd0);
            rd(c, 8'h1C, d); check("R1 cq head", 64'(d), 64'd0);
            rd(c, 8'h20, d); check("R1 control", 64'(d), 64'd0);
            rd(c, 8'h40, d); check("R1 status", 64'(d), 64'd0);
            rd(c, 8'h44, d); check("R1 mask", 64'(d), 64'h1FFF);
        end
        check("R1 irq", 64'(irq), 64'd0);

        // R2 read-back and channel independence
        wr(0, 8'h00, 32'hA5A5_0000); wr(0, 8'h04, 32'h1234_5678);
        wr(0, 8'h10, 32'h0BAD_0040); wr(0, 8'h14, 32'h0000_FFFF);
        wr(0, 8'h08, 32'd7);         wr(0, 8'h18, 32'd9);
        wr(0, 8'h1C, 32'd5);
        wr(1, 8'h00, 32'h1111_2222); wr(1, 8'h04, 32'h3333_4444);
        wr(1, 8'h1C, 32'd3);
        rd(0, 8'h00, d); check("R2 sub lo", 64'(d), 64'hA5A5_0000);
        rd(0, 8'h04, d); check("R2 sub hi", 64'(d), 64'h1234_5678);
        rd(0, 8'h10, d); check("R2 cpl lo", 64'(d), 64'h0BAD_0040);
        rd(0, 8'h14, d); check("R2 cpl hi", 64'(d), 64'h0000_FFFF);
        rd(0, 8'h08, d); check("R2 sub depth", 64'(d), 64'd7);
        rd(0, 8'h18, d); check("R2 cpl depth", 64'(d), 64'd9);
        rd(0, 8'h1C, d); check("R2 cpl head ch0", 64'(d), 64'd5);
        rd(1, 8'h1C, d); check("R2 cpl head ch1", 64'(d), 64'd3);
        rd(1, 8'h00, d); check("R2 sub lo ch1", 64'(d), 64'h1111_2222);
        check("R2 sub base port ch0", eng_sq_base[63:0], 64'h1234_5678_A5A5_0000);
        check("R2 cpl base port ch0", eng_cq_base[63:0], 64'h0000_FFFF_0BAD_0040);
        check("R2 sub base port ch1", eng_sq_base[127:64], 64'h3333_4444_1111_2222);
        wr(0, 8'h20, 32'h11); rd(0, 8'h20, d); check("R2 control", 64'(d), 64'h11);
        rd(1, 8'h20, d); check("R2 control ch1 untouched", 64'(d), 64'h0);
        wr(0, 8'h20, 32'h0);
        last_m[0] = 7;

        // R3 disabled channel starts nothing
        eng_ien[0] = 1'b0; lat = 2;
        wr(0, 8'h0C, 32'd2);
        idle(30);
        check("R3 disabled no start", 64'(starts[0]), 64'd0);
        rd(0, 8'h30, d); check("R3 disabled idle", 64'(d), 64'd0);
        wr(0, 8'h20, 32'h01);
        idle(40);
        check("R4 two elements", 64'(starts[0]), 64'd2);
        rd(0, 8'h30, d); check("R4 back to idle", 64'(d), 64'd0);
        rd(0, 8'h40, d); check("R7 no flag without ien", 64'(d), 64'd0);

        // R7/R8 completion flag, mask, clear
        eng_ien[0] = 1'b1;
        wr(0, 8'h0C, 32'd3);
        idle(25);
        check("R4 third element", 64'(starts[0]), 64'd3);
        rd(0, 8'h40, d); check("R7 done flag", 64'(d), 64'd1);
        check("R8 masked irq low", 64'(irq[0]), 64'd0);
        wr(0, 8'h44, 32'h0);
        check("R8 unmasked irq high", 64'(irq[0]), 64'd1);
        check("R8 other channel irq low", 64'(irq[1]), 64'd0);
        wr(0, 8'h40, 32'h1FFF);
        check("R8 irq after clear", 64'(irq[0]), 64'd0);
        rd(0, 8'h40, d); check("R7 status cleared", 64'(d), 64'd0);

        // R5 pause after current element
        lat = 10;
        wr(0, 8'h0C, 32'd6);
        idle(4);
        wr(0, 8'h20, 32'h11);
        idle(60);
        check("R5 only in-flight element done", 64'(starts[0]), 64'd4);
        rd(0, 8'h30, d); check("R5 pause state", 64'(d), 64'd3);
        wr(0, 8'h20, 32'h01);
        idle(60);
        check("R5 resumes", 64'(starts[0]), 64'd6);
        rd(0, 8'h30, d); check("R5 idle after resume", 64'(d), 64'd0);

        // R7 error halts; R6 reset
        lat = 1; eng_err[0] = 1'b1;
        wr(0, 8'h40, 32'hFFFF_FFFF);
        wr(0, 8'h0C, 32'd7);
        idle(20);
        rd(0, 8'h30, d); check("R7 halt state", 64'(d), 64'd4);
        rd(0, 8'h40, d); check("R7 fault flag", 64'(d), 64'd2);
        eng_err[0] = 1'b0;
        wr(0, 8'h0C, 32'd0);
        idle(20);
        check("R7 halt holds", 64'(starts[0]), 64'd7);
        rd(0, 8'h30, d); check("R7 still halt", 64'(d), 64'd4);
        wr(0, 8'h24, 32'd1);
        rd(0, 8'h30, d); check("R6 flush state", 64'(d), 64'd7);
        rd(0, 8'h30, d); check("R6 idle after flush", 64'(d), 64'd0);
        rd(0, 8'h24, d); check("R6 request self clears", 64'(d), 64'd0);
        rd(0, 8'h0C, d); check("R6 tail cleared", 64'(d), 64'd0);
        rd(0, 8'h1C, d); check("R6 cq head cleared", 64'(d), 64'd0);
        exp_idx[0] = 0;
        wr(0, 8'h0C, 32'd1);
        idle(20);
        check("R6 head restarts at 0", 64'(starts[0]), 64'd8);
        rd(0, 8'h30, d); check("R6 idle after element", 64'(d), 64'd0);

        // R4 wrap sweep on channel 1 over several ring sizes
        wr(1, 8'h20, 32'h01);
        foreach (starts[c]) if (c == 1) starts[c] = 0;
        for (int k = 0; k < 6; k++) begin
            n = (k == 0) ? 2 : (k == 1) ? 3 : (k == 2) ? 5 : (k == 3) ? 7 : (k == 4) ? 8 : 16;
            lat = n % 4;
            wr(1, 8'h24, 32'd1);
            idle(3);
            wr(1, 8'h08, 32'(n - 1));
            last_m[1] = n - 1; exp_idx[1] = 0; starts[1] = 0;
            t = 0; total = 0; round = 0;
            while (total < 2 * n + 2) begin
                int step;
                step = 1 + (round % (n - 1));
                t = (t + step) % n;
                wr(1, 8'h0C, 32'(t));
                total += step; round++;
                idle(step * (lat + 8) + 10);
            end
            check("R4 wrap element count", 64'(starts[1]), 64'(total));
            rd(1, 8'h30, d); check("R4 wrap ends idle", 64'(d), 64'd0);
        end
        check("R2 ch0 untouched by sweep", 64'(starts[0]), 64'd8);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule